// File: doc/BRIEF.md
# Sequential Keypad Code Lock

A synchronous lock that watches key-press events from a keypad and walks a one-hot progress register forward as the digits of a fixed secret code are entered in order. A press that matches the digit expected at the current position moves progress on by one. Any other press sends progress back to the start. Once every digit has been entered, the final progress bit drives an unlock output, which stays high until the next key press relocks the lock.

Key events arrive as a one-hot key bus qualified by a one-cycle valid strobe. Each strobe is evaluated in the clock cycle in which it is sampled. The advance decision masks the return-to-start decision, so a correct key never clears progress. The code length (1 to 8 digits) and the digit values are parameters. Keypad scanning, debouncing and output driving are handled outside the block.

Top module: `seq_code_lock`

## Requirements
- R1: `stage` is one-hot and is CODE_LEN+1 bits wide. Bit k high means that exactly k code digits have been accepted.
- R2: A press with exactly one key line high, that key's index equal to code digit k, and `stage` bit k high (k < CODE_LEN) moves the one-hot bit from position k to k+1 at the clock edge that samples `key_valid`.
- R3: Any other press while locked returns `stage` to bit 0 at that edge. This includes a key equal to the first digit pressed at a later position, which does not count as a fresh first digit.
- R4: When `stage` bit CODE_LEN is set, `unlocked` is high, and it stays high for as long as no press arrives.
- R5: Any press while unlocked, whatever its key, returns `stage` to bit 0 and drops `unlocked` at that edge.
- R6: A press with zero key lines or with two or more key lines high counts as a wrong key (R3 behaviour).
- R7: A synchronous active-high `rst` puts `stage` at bit 0 with `unlocked` low at the next edge, mid-code or unlocked.
- R8: While `key_valid` is low, `key_hot` has no effect on `stage` or `unlocked`.
- R9: Code digit k sits in bits [4k+3:4k] of the CODE parameter and holds a key index from 0 to 9. Key n is line n of `key_hot`. The same logic serves a 4-digit code and an 8-digit code, and in the 8-digit case stage bit 8 drives `unlocked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | One-cycle strobe marking a key event |
| key_hot | input | NUM_KEYS | One-hot key lines, bit n = key n |
| unlocked | output | 1 | High once the full code has been entered |
| stage | output | CODE_LEN+1 | One-hot progress register |

## Verification
The assertions assume that `key_valid` is a single-cycle strobe per key event and that `rst` is held for at least one edge before the first event. The assertions do not constrain `key_hot`: any pattern, including none or several lines, is legal while `key_valid` is high. The stimulus raises `key_valid` for exactly one cycle per press, with `key_hot` changed only on the falling edge. It also changes `key_hot` in cycles where `key_valid` is low, which exercises the idle case without breaking the strobe assumption.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int DIGIT_W = 4;
  localparam int MAX_LEN = 8;
  localparam int MAX_KEYS = 16;

  // nibble k of the packed code word
  function automatic int code_digit(input logic [DIGIT_W*MAX_LEN-1:0] code, input int k);
    return int'(code[DIGIT_W*k +: DIGIT_W]);
  endfunction

  // number of key lines asserted
  function automatic int key_count(input logic [MAX_KEYS-1:0] lines);
    int n;
    n = 0;
    for (int i = 0; i < MAX_KEYS; i++) n += int'(lines[i]);
    return n;
  endfunction
endpackage

// File: rtl/lock_key_decode.sv
module lock_key_decode #(
  parameter int NUM_KEYS = 10
) (
  input  logic [NUM_KEYS-1:0] key_hot,
  output logic                key_single
);
  import lock_pkg::*;
  logic [MAX_KEYS-1:0] lines_ext;

  always_comb begin
    lines_ext = '0;
    lines_ext[NUM_KEYS-1:0] = key_hot;
    key_single = (key_count(lines_ext) == 1);
  end
endmodule

// File: rtl/lock_stage_match.sv
module lock_stage_match #(
  parameter int NUM_KEYS = 10,
  parameter int CODE_LEN = 4,
  parameter logic [31:0] CODE = 32'h0000_9173
) (
  input  logic                key_valid,
  input  logic                key_single,
  input  logic [NUM_KEYS-1:0] key_hot,
  input  logic [CODE_LEN-1:0] stage_open,
  output logic                adv_pulse,
  output logic                clr_pulse
);
  import lock_pkg::*;
  logic [CODE_LEN-1:0] hit;

  // each open stage gates exactly one key line
  for (genvar k = 0; k < CODE_LEN; k++) begin : g_gate
    localparam int DK = code_digit(CODE, k);
    assign hit[k] = stage_open[k] & key_hot[DK];
  end

  always_comb begin
    adv_pulse = key_valid & key_single & (|hit);
    // every press requests a clear; an advance masks it
    clr_pulse = key_valid & ~adv_pulse;
  end
endmodule

// File: rtl/lock_stage_reg.sv
module lock_stage_reg #(
  parameter int ST_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_pulse,
  input  logic            clr_pulse,
  output logic [ST_W-1:0] stage
);
  localparam logic [ST_W-1:0] START = ST_W'(1);

  always_ff @(posedge clk) begin
    if (rst)            stage <= START;
    else if (adv_pulse) stage <= {stage[ST_W-2:0], 1'b0};
    else if (clr_pulse) stage <= START;
  end
endmodule

// File: rtl/seq_code_lock.sv
module seq_code_lock #(
  parameter int NUM_KEYS = 10,
  parameter int CODE_LEN = 4,
  parameter logic [31:0] CODE = 32'h0000_9173
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                key_valid,
  input  logic [NUM_KEYS-1:0] key_hot,
  output logic                unlocked,
  output logic [CODE_LEN:0]   stage
);
  localparam int ST_W = CODE_LEN + 1;

  logic key_single;
  logic adv_pulse;
  logic clr_pulse;

  lock_key_decode #(.NUM_KEYS(NUM_KEYS)) u_dec (
    .key_hot   (key_hot),
    .key_single(key_single)
  );

  lock_stage_match #(.NUM_KEYS(NUM_KEYS), .CODE_LEN(CODE_LEN), .CODE(CODE)) u_match (
    .key_valid (key_valid),
    .key_single(key_single),
    .key_hot   (key_hot),
    .stage_open(stage[CODE_LEN-1:0]),
    .adv_pulse (adv_pulse),
    .clr_pulse (clr_pulse)
  );

  lock_stage_reg #(.ST_W(ST_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .adv_pulse(adv_pulse),
    .clr_pulse(clr_pulse),
    .stage    (stage)
  );

  assign unlocked = stage[CODE_LEN];
endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int CODE_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              key_valid,
  input logic [CODE_LEN:0] stage,
  input logic              unlocked,
  input logic              adv_pulse,
  input logic              clr_pulse
);
  localparam logic [CODE_LEN:0] START = (CODE_LEN+1)'(1);

  assert_onehot_stage_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(stage) == 1);

  assert_advance_shift_R2: assert property (@(posedge clk) disable iff (rst)
    adv_pulse |=> stage == ($past(stage) << 1));

  assert_adv_masks_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !(adv_pulse && clr_pulse));

  assert_clear_to_start_R3: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> stage == START);

  assert_unlock_by_advance_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(adv_pulse));

  assert_relock_R5: assert property (@(posedge clk) disable iff (rst)
    (unlocked && key_valid) |=> (!unlocked && stage == START));

  assert_no_adv_unlocked_R5: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> !adv_pulse);

  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> (stage == START && !unlocked));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !key_valid |=> $stable(stage));
endmodule

bind seq_code_lock lock_checker #(.CODE_LEN(CODE_LEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .key_valid(key_valid),
  .stage    (stage),
  .unlocked (unlocked),
  .adv_pulse(adv_pulse),
  .clr_pulse(clr_pulse)
);

// File: tb/sim_seq_code_lock.sv
module sim_seq_code_lock;
  logic clk = 0;
  logic rst = 1;
  logic key_valid = 0;
  logic [9:0] key_hot = '0;
  logic unl4, unl8;
  logic [4:0] st4;
  logic [8:0] st8;

  int n_chk = 0, n_fail = 0;
  bit live = 0, done = 0;
  int code4 [4] = '{3, 7, 1, 9};
  int code8 [8] = '{5, 0, 2, 8, 8, 6, 4, 1};
  int prog4 = 0, prog8 = 0;

  always #5 clk = ~clk;

  seq_code_lock #(.NUM_KEYS(10), .CODE_LEN(4), .CODE(32'h0000_9173)) u0 (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_hot(key_hot),
    .unlocked(unl4), .stage(st4));

  seq_code_lock #(.NUM_KEYS(10), .CODE_LEN(8), .CODE(32'h1468_8205)) u1 (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_hot(key_hot),
    .unlocked(unl8), .stage(st8));

  function automatic int ones(input logic [9:0] v);
    int c = 0;
    foreach (v[i]) c += int'(v[i]);
    return c;
  endfunction

  function automatic int idx(input logic [9:0] v);
    int r = -1;
    foreach (v[i]) if (v[i]) r = i;
    return r;
  endfunction

  // behavioural reference: progress counters updated per press
  always @(posedge clk) begin
    if (rst) begin
      prog4 = 0; prog8 = 0;
    end else if (key_valid) begin
      if (prog4 == 4) prog4 = 0;
      else if (ones(key_hot) == 1 && idx(key_hot) == code4[prog4]) prog4++;
      else prog4 = 0;
      if (prog8 == 8) prog8 = 0;
      else if (ones(key_hot) == 1 && idx(key_hot) == code8[prog8]) prog8++;
      else prog8 = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (live && !rst) begin
    chk(st4 == 5'(1 << prog4), "R1 R2 R3 model stage4", st4, 1 << prog4);
    chk(unl4 == (prog4 == 4), "R4 R5 model unlocked4", unl4, prog4 == 4);
    chk(st8 == 9'(1 << prog8), "R1 R9 model stage8", st8, 1 << prog8);
    chk(unl8 == (prog8 == 8), "R4 R9 model unlocked8", unl8, prog8 == 8);
  end

  task automatic press(input logic [9:0] lines);
    @(negedge clk); key_valid = 1; key_hot = lines;
    @(negedge clk); key_valid = 0; key_hot = '0;
  endtask

  task automatic key(input int d);
    press(10'(1 << d));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; live = 1;
    chk(st4 == 5'b00001 && !unl4, "R7 reset state", st4, 1);

    // correct 4-digit code
    foreach (code4[i]) begin
      key(code4[i]);
      chk(st4 == 5'(2 << i), "R2 advance", st4, 2 << i);
    end
    chk(unl4 == 1, "R4 unlocked after code", unl4, 1);
    repeat (5) @(negedge clk);
    chk(unl4 == 1, "R4 unlock holds", unl4, 1);
    key_hot = 10'h3FF; repeat (2) @(negedge clk); key_hot = '0;
    chk(unl4 == 1 && st4 == 5'b10000, "R8 idle lines ignored", st4, 5'b10000);
    key(3);
    chk(!unl4 && st4 == 5'b00001, "R5 relock with any key", st4, 1);

    // wrong digit at every position
    for (int p = 0; p < 4; p++) begin
      for (int j = 0; j < p; j++) key(code4[j]);
      key((code4[p] + 2) % 10);
      chk(st4 == 5'b00001, $sformatf("R3 wrong at pos %0d", p), st4, 1);
    end
    key(3); key(7); key(3);
    chk(st4 == 5'b00001, "R3 first digit mid-code", st4, 1);

    // multi-key and no-key presses
    key(3); press(10'((1 << 7) | (1 << 2)));
    chk(st4 == 5'b00001, "R6 two keys wrong", st4, 1);
    key(3); press('0);
    chk(st4 == 5'b00001, "R6 no key wrong", st4, 1);

    // idle key lines mid-code
    key(3); key(7);
    @(negedge clk); key_hot = 10'(1 << 1); repeat (3) @(negedge clk); key_hot = '0;
    chk(st4 == 5'b00100, "R8 no strobe no change", st4, 5'b00100);

    // reset mid-code
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk(st4 == 5'b00001 && st8 == 9'b1, "R7 reset mid-code", st4, 1);

    // 8-digit configuration
    foreach (code8[i]) key(code8[i]);
    chk(unl8 == 1 && st8 == 9'h100, "R9 8-digit unlock", st8, 9'h100);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk(!unl8 && st8 == 9'b1, "R7 reset while unlocked", st8, 1);
    for (int p = 0; p < 8; p++) begin
      for (int j = 0; j < p; j++) key(code8[j]);
      key((code8[p] + 3) % 10);
      chk(st8 == 9'b1, $sformatf("R9 R3 wrong at pos %0d", p), st8, 1);
    end
    foreach (code8[i]) key(code8[i]);
    key(9);
    chk(!unl8 && st8 == 9'b1, "R5 relock 8-digit", st8, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule